// File: doc/BRIEF.md
# E1 Transmit Overhead Inserter

This block sits in the transmit path of a 2048 kbit/s E1 link, between the backplane and the line coder. It takes a serial NRZ payload, one bit per clock, together with a frame pulse that marks the first bit of each 256-bit frame. It builds the outgoing stream by replacing the bits of slot 0 with framing overhead and the bits of slot 16 with signaling or data-link content. It sends the result out one clock later with a matching delayed frame pulse.

Slot 0 carries the frame alignment word in even frames. In odd frames it carries the non-alignment word: fixed ones, a remote alarm bit, and five national-use bits. Each national-use bit is taken from a serial input when its own enable is set and is sent as one otherwise. Static controls let either overhead slot be passed through untouched, force an all-ones alarm stream, or switch the whole block to unframed operation, in which every input bit is copied to the output unchanged.

Top module: `e1_tx_ovh_ins`

## Requirements
- R1: While rst_n is low, tx_data_o and tx_fp_o are both 0, whatever the other inputs do.
- R2: tx_fp_o equals bp_fp_i delayed by one clock. Bits in slots other than 0 and 16 appear on tx_data_o one clock after they enter on bp_data_i.
- R3: In an even frame, slot 0 is sent as 1,0,0,1,1,0,1,1. Bits are numbered 1 to 8 within a slot, bit 1 is sent first, and bit k of slot s is frame bit position 8*s+k-1.
- R4: In an odd frame, slot 0 bits 1 and 2 are sent as 1, bit 3 equals cfg_rai_i, and bits 4 to 8 are sent as 1 when their national-use enables are clear.
- R5: In an odd frame, when cfg_sa_en_i[k] is set (k = 0..4, covering slot 0 bits 4 to 8), that bit is sent as the value of sa_data_i in the same clock.
- R6: When cfg_ts0_pass_i or cfg_fdis_i is set, slot 0 is copied from bp_data_i unchanged.
- R7: In slot 16, cfg_sig_en_i selects sig_data_i. Otherwise cfg_dl_en_i selects dl_data_i. With both clear, slot 16 is copied from bp_data_i.
- R8: When cfg_ts16_pass_i is set, slot 16 is copied from bp_data_i whatever the two enables are.
- R9: When cfg_ais_i is set and cfg_unframed_i is clear, every output bit is 1, including both overhead slots.
- R10: When cfg_unframed_i is set, the output equals the input bit for bit. This holds even with the alarm, signaling, data-link and national-use controls set.
- R11: A frame pulse makes the clock in which it is high frame bit position 0. A pulse that arrives anywhere other than an expected frame start begins an even frame.
- R12: Frame parity starts even after reset and alternates on each 256-bit frame when pulses arrive at the expected frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_data_i | input | 1 | Serial payload from the backplane |
| bp_fp_i | input | 1 | High with frame bit position 0 |
| sa_data_i | input | 1 | Serial national-use bit source |
| sig_data_i | input | 1 | Serial signaling source for slot 16 |
| dl_data_i | input | 1 | Serial data-link source for slot 16 |
| cfg_unframed_i | input | 1 | Copy input to output with no overwrite |
| cfg_ais_i | input | 1 | Force all-ones output |
| cfg_ts0_pass_i | input | 1 | Pass slot 0 unchanged |
| cfg_fdis_i | input | 1 | Disable framing overhead insertion |
| cfg_ts16_pass_i | input | 1 | Pass slot 16 unchanged |
| cfg_sig_en_i | input | 1 | Insert signaling into slot 16 |
| cfg_dl_en_i | input | 1 | Insert data link into slot 16 |
| cfg_rai_i | input | 1 | Remote alarm bit for odd frames |
| cfg_sa_en_i | input | 5 | Per-bit national-use insert enables |
| tx_data_o | output | 1 | Serial E1 NRZ output |
| tx_fp_o | output | 1 | Frame pulse aligned to tx_data_o |

## Verification
The hardest case to reach is a frame pulse that lands in the middle of a frame after the parity register has already settled into a pattern. The parity only resets if the misaligned pulse is recognised, and a design that just reloads the counter will carry on with the old alternation. The bench runs a long stretch of unpulsed bits, then places a pulse at an arbitrary position, and checks the slot 0 content of the frames that follow. The national-use bits are also hard to observe, because they appear only in odd frames. The stimulus therefore always runs frame pairs and uses sparse enable masks.

// File: rtl/e1_ovh_pkg.sv
package e1_ovh_pkg;
    // number of national-use bits carried in the odd-frame overhead word
    localparam int unsigned SA_COUNT = 5;
    // first national-use bit counted from the start of the slot (bit 4 -> index 3)
    localparam int unsigned SA_FIRST = 3;
    // even-frame alignment word, first-sent bit in the MSB
    localparam logic [7:0] ALIGN_WORD = 8'b1001_1011;

    typedef struct packed {
        logic data;
        logic fp;
    } txo_t;
endpackage

// File: rtl/e1_tx_timebase.sv
module e1_tx_timebase #(
    parameter int unsigned SLOTS     = 32,
    parameter int unsigned SLOT_BITS = 8,
    localparam int unsigned FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int unsigned POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    output logic [POS_W-1:0] pos_o,
    output logic             odd_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             par;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [POS_W-1:0] pos;
    logic             odd;

    always_comb begin
        // pulse forces position zero; a pulse off the expected start restarts even
        pos  = fp_i ? '0 : st_q.cnt;
        odd  = (fp_i && (st_q.cnt != '0)) ? 1'b0 : st_q.par;
        st_d = st_q;
        if (pos == LAST_POS) begin
            st_d.cnt = '0;
            st_d.par = ~odd;
        end else begin
            st_d.cnt = pos + 1'b1;
            st_d.par = odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = pos;
    assign odd_o = odd;
endmodule

// File: rtl/e1_ts0_builder.sv
module e1_ts0_builder
    import e1_ovh_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 8,
    localparam int unsigned BIT_W = $clog2(SLOT_BITS)
) (
    input  logic [BIT_W-1:0]    bit_idx_i,
    input  logic                odd_i,
    input  logic                rai_i,
    input  logic [SA_COUNT-1:0] sa_en_i,
    input  logic                sa_data_i,
    output logic                ovh_bit_o
);
    localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(SLOT_BITS - 1);

    logic [SLOT_BITS-1:0] odd_word;

    assign odd_word[SLOT_BITS-1] = 1'b1;
    assign odd_word[SLOT_BITS-2] = 1'b1;
    assign odd_word[SLOT_BITS-3] = rai_i;

    for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
        assign odd_word[SLOT_BITS-1-SA_FIRST-k] = sa_en_i[k] ? sa_data_i : 1'b1;
    end

    always_comb begin
        if (odd_i) begin
            ovh_bit_o = odd_word[TOP_IDX - bit_idx_i];
        end else begin
            ovh_bit_o = ALIGN_WORD[TOP_IDX - bit_idx_i];
        end
    end
endmodule

// File: rtl/e1_slot_sel.sv
module e1_slot_sel #(
    parameter int unsigned SLOTS    = 32,
    parameter int unsigned SIG_SLOT = 16,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              payload_i,
    input  logic              ovh_bit_i,
    input  logic              sig_data_i,
    input  logic              dl_data_i,
    input  logic              unframed_i,
    input  logic              ais_i,
    input  logic              ts0_pass_i,
    input  logic              fdis_i,
    input  logic              ts16_pass_i,
    input  logic              sig_en_i,
    input  logic              dl_en_i,
    output logic              bit_o
);
    localparam logic [SLOT_W-1:0] SIG_IDX = SLOT_W'(SIG_SLOT);

    logic ts0_write;
    logic ts16_write;

    always_comb begin
        ts0_write  = (slot_i == '0) && !ts0_pass_i && !fdis_i;
        ts16_write = (slot_i == SIG_IDX) && !ts16_pass_i && (sig_en_i || dl_en_i);
        if (unframed_i) begin
            bit_o = payload_i;
        end else if (ais_i) begin
            bit_o = 1'b1;
        end else if (ts0_write) begin
            bit_o = ovh_bit_i;
        end else if (ts16_write) begin
            bit_o = sig_en_i ? sig_data_i : dl_data_i;
        end else begin
            bit_o = payload_i;
        end
    end
endmodule

// File: rtl/e1_tx_ovh_ins.sv
module e1_tx_ovh_ins
    import e1_ovh_pkg::*;
#(
    parameter int unsigned SLOTS     = 32,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned SIG_SLOT  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bp_data_i,
    input  logic                bp_fp_i,
    input  logic                sa_data_i,
    input  logic                sig_data_i,
    input  logic                dl_data_i,
    input  logic                cfg_unframed_i,
    input  logic                cfg_ais_i,
    input  logic                cfg_ts0_pass_i,
    input  logic                cfg_fdis_i,
    input  logic                cfg_ts16_pass_i,
    input  logic                cfg_sig_en_i,
    input  logic                cfg_dl_en_i,
    input  logic                cfg_rai_i,
    input  logic [SA_COUNT-1:0] cfg_sa_en_i,
    output logic                tx_data_o,
    output logic                tx_fp_o
);
    localparam int unsigned POS_W  = $clog2(SLOTS * SLOT_BITS);
    localparam int unsigned BIT_W  = $clog2(SLOT_BITS);
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    logic [POS_W-1:0]  bit_pos;
    logic              frame_odd;
    logic              ovh_bit;
    logic              sel_bit;
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;

    txo_t out_d, out_q;

    e1_tx_timebase #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .fp_i  (bp_fp_i),
        .pos_o (bit_pos),
        .odd_o (frame_odd)
    );

    assign cur_slot = bit_pos[POS_W-1:BIT_W];
    assign cur_bit  = bit_pos[BIT_W-1:0];

    e1_ts0_builder #(
        .SLOT_BITS (SLOT_BITS)
    ) u_ts0 (
        .bit_idx_i (cur_bit),
        .odd_i     (frame_odd),
        .rai_i     (cfg_rai_i),
        .sa_en_i   (cfg_sa_en_i),
        .sa_data_i (sa_data_i),
        .ovh_bit_o (ovh_bit)
    );

    e1_slot_sel #(
        .SLOTS    (SLOTS),
        .SIG_SLOT (SIG_SLOT)
    ) u_sel (
        .slot_i      (cur_slot),
        .payload_i   (bp_data_i),
        .ovh_bit_i   (ovh_bit),
        .sig_data_i  (sig_data_i),
        .dl_data_i   (dl_data_i),
        .unframed_i  (cfg_unframed_i),
        .ais_i       (cfg_ais_i),
        .ts0_pass_i  (cfg_ts0_pass_i),
        .fdis_i      (cfg_fdis_i),
        .ts16_pass_i (cfg_ts16_pass_i),
        .sig_en_i    (cfg_sig_en_i),
        .dl_en_i     (cfg_dl_en_i),
        .bit_o       (sel_bit)
    );

    always_comb begin
        out_d      = out_q;
        out_d.data = sel_bit;
        out_d.fp   = bp_fp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tx_data_o = out_q.data;
    assign tx_fp_o   = out_q.fp;
endmodule

// File: rtl/e1_tx_ovh_ins_chk.sv
module e1_tx_ovh_ins_chk #(
    parameter int unsigned SLOTS     = 32,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned SIG_SLOT  = 16,
    localparam int unsigned POS_W  = $clog2(SLOTS * SLOT_BITS),
    localparam int unsigned BIT_W  = $clog2(SLOT_BITS),
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bp_data_i,
    input logic             bp_fp_i,
    input logic             cfg_unframed_i,
    input logic             cfg_ais_i,
    input logic             cfg_ts0_pass_i,
    input logic             cfg_fdis_i,
    input logic             cfg_ts16_pass_i,
    input logic [POS_W-1:0] bit_pos,
    input logic             tx_data_o,
    input logic             tx_fp_o
);
    localparam logic [SLOT_W-1:0] SIG_IDX = SLOT_W'(SIG_SLOT);
    localparam logic [POS_W-1:0]  ONE_POS = POS_W'(1);

    logic              seen_q;
    logic [SLOT_W-1:0] slot;
    logic              plain;

    assign slot  = bit_pos[POS_W-1:BIT_W];
    assign plain = !cfg_ais_i && !cfg_unframed_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    // R2
    fp_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> tx_fp_o == $past(bp_fp_i));

    // R2
    payload_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(plain && slot != '0 && slot != SIG_IDX) |-> tx_data_o == $past(bp_data_i));

    // R6
    ts0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(plain && slot == '0 && (cfg_ts0_pass_i || cfg_fdis_i)) |-> tx_data_o == $past(bp_data_i));

    // R8
    ts16_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(plain && slot == SIG_IDX && cfg_ts16_pass_i) |-> tx_data_o == $past(bp_data_i));

    // R9
    ais_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(cfg_ais_i && !cfg_unframed_i) |-> tx_data_o);

    // R10
    unframed_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(cfg_unframed_i) |-> tx_data_o == $past(bp_data_i));

    // R11
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(bp_fp_i) && !bp_fp_i |-> bit_pos == ONE_POS);
endmodule

bind e1_tx_ovh_ins e1_tx_ovh_ins_chk #(
    .SLOTS     (SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .SIG_SLOT  (SIG_SLOT)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bp_data_i       (bp_data_i),
    .bp_fp_i         (bp_fp_i),
    .cfg_unframed_i  (cfg_unframed_i),
    .cfg_ais_i       (cfg_ais_i),
    .cfg_ts0_pass_i  (cfg_ts0_pass_i),
    .cfg_fdis_i      (cfg_fdis_i),
    .cfg_ts16_pass_i (cfg_ts16_pass_i),
    .bit_pos         (bit_pos),
    .tx_data_o       (tx_data_o),
    .tx_fp_o         (tx_fp_o)
);

// File: tb/e1_tx_ovh_ins_test.sv
module e1_tx_ovh_ins_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // {req[3:0], unframed, ais, ts0_pass, fdis, ts16_pass, sig_en, dl_en, rai, sa_en[4:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {4'd3,  8'b0000_0000, 5'b00000},  // R3 R4 R7: defaults, slot 16 passes
        {4'd4,  8'b0000_0001, 5'b00000},  // R4: remote alarm set
        {4'd5,  8'b0000_0001, 5'b10101},  // R5: sparse national-use mask
        {4'd5,  8'b0000_0000, 5'b11111},  // R5: all national-use bits inserted
        {4'd6,  8'b0001_0000, 5'b11111},  // R6: framing disabled
        {4'd6,  8'b0010_0000, 5'b00000},  // R6: slot 0 pass
        {4'd7,  8'b0000_0100, 5'b00000},  // R7: signaling
        {4'd7,  8'b0000_0010, 5'b00000},  // R7: data link
        {4'd7,  8'b0000_0110, 5'b00000},  // R7: signaling wins
        {4'd8,  8'b0000_1110, 5'b00000},  // R8: slot 16 pass overrides
        {4'd9,  8'b0100_0101, 5'b11111},  // R9: alarm ones
        {4'd10, 8'b1111_1111, 5'b11111},  // R10: unframed beats everything
        {4'd10, 8'b1000_0000, 5'b00000}   // R10: unframed alone
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       bp_data_i = 1'b0, bp_fp_i = 1'b0, sa_data_i = 1'b0;
    logic       sig_data_i = 1'b0, dl_data_i = 1'b0;
    logic [12:0] cfg = '0;
    logic       tx_data_o, tx_fp_o;

    e1_tx_ovh_ins uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bp_data_i       (bp_data_i),
        .bp_fp_i         (bp_fp_i),
        .sa_data_i       (sa_data_i),
        .sig_data_i      (sig_data_i),
        .dl_data_i       (dl_data_i),
        .cfg_unframed_i  (cfg[12]),
        .cfg_ais_i       (cfg[11]),
        .cfg_ts0_pass_i  (cfg[10]),
        .cfg_fdis_i      (cfg[9]),
        .cfg_ts16_pass_i (cfg[8]),
        .cfg_sig_en_i    (cfg[7]),
        .cfg_dl_en_i     (cfg[6]),
        .cfg_rai_i       (cfg[5]),
        .cfg_sa_en_i     (cfg[4:0]),
        .tx_data_o       (tx_data_o),
        .tx_fp_o         (tx_fp_o)
    );

    int checks = 0;
    int fails = 0;
    logic [15:0] lfsr = 16'hACE1;
    int  bpos = 0;
    bit  bpar = 1'b0;
    bit  have_prev = 1'b0;
    bit  p_exp, p_fp;
    int  p_idx, p_slot, p_tag;
    logic [7:0] acc_got, acc_exp;
    int  scen_req = 3;

    function automatic bit model(bit d, int slot, int idx, bit odd, logic [12:0] c,
                                 bit sa, bit sg, bit dl);
        logic [7:0] fas;
        fas = 8'b1001_1011;
        if (c[12]) return d;                      // R10
        if (c[11]) return 1'b1;                   // R9
        if (slot == 0 && !c[10] && !c[9]) begin   // R6
            if (!odd) return fas[7-idx];          // R3
            if (idx < 2) return 1'b1;             // R4
            if (idx == 2) return c[5];
            return c[idx-3] ? sa : 1'b1;          // R5
        end
        if (slot == 16 && !c[8] && (c[7] || c[6])) return c[7] ? sg : dl;  // R7 R8
        return d;                                 // R2
    endfunction

    task automatic check(bit ok, int req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(bit fp, logic [12:0] c);
        int  cur;
        bit  odd;
        @(negedge clk);
        if (have_prev) begin
            if (p_fp || tx_fp_o)
                check(tx_fp_o == p_fp, 2, "frame pulse delay", int'(tx_fp_o), int'(p_fp));
            if (p_idx == 0) begin
                acc_got = '0;
                acc_exp = '0;
            end
            acc_got[7-p_idx] = tx_data_o;
            acc_exp[7-p_idx] = p_exp;
            if (p_idx == 7)
                check(acc_got == acc_exp, p_tag, $sformatf("slot %0d", p_slot),
                      int'(acc_got), int'(acc_exp));
        end
        cfg = c;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bp_data_i  = lfsr[0];
        sa_data_i  = lfsr[5];
        sig_data_i = lfsr[9];
        dl_data_i  = lfsr[13];
        bp_fp_i    = fp;
        // R11: pulse sets position zero, off-start pulse starts an even frame
        cur = fp ? 0 : bpos;
        odd = (fp && bpos != 0) ? 1'b0 : bpar;
        p_exp  = model(bp_data_i, cur / 8, cur % 8, odd, c, sa_data_i, sig_data_i, dl_data_i);
        p_fp   = fp;
        p_idx  = cur % 8;
        p_slot = cur / 8;
        p_tag  = (p_slot != 0 && p_slot != 16 && !c[11] && !c[12]) ? 2 : scen_req;
        have_prev = 1'b1;
        // R12: parity alternates at each frame wrap
        if (cur == 255) begin
            bpos = 0;
            bpar = ~odd;
        end else begin
            bpos = cur + 1;
            bpar = odd;
        end
    endtask

    task automatic run_frames(int n, logic [12:0] c);
        for (int f = 0; f < n; f++)
            for (int b = 0; b < 256; b++)
                tick(b == 0, c);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset while inputs are active
        cfg = 13'b0100_0000_00000;
        bp_data_i = 1'b1;
        bp_fp_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tx_data_o == 1'b0, 1, "data in reset", int'(tx_data_o), 0);
        check(tx_fp_o == 1'b0, 1, "pulse in reset", int'(tx_fp_o), 0);
        bp_fp_i = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            scen_req = int'(VEC[i][16:13]);
            run_frames(2, VEC[i][12:0]);
        end

        // R11: long unpulsed stretch, then a pulse at an arbitrary position
        scen_req = 11;
        for (int k = 0; k < 99; k++) tick(1'b0, '0);
        run_frames(3, '0);

        // R1: reset mid-run, then R12: parity restarts even
        @(negedge clk);
        rst_n = 1'b0;
        bp_data_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(tx_data_o == 1'b0, 1, "data after mid-run reset", int'(tx_data_o), 0);
        check(tx_fp_o == 1'b0, 1, "pulse after mid-run reset", int'(tx_fp_o), 0);
        rst_n = 1'b1;
        bpos = 0;
        bpar = 1'b0;
        have_prev = 1'b0;
        scen_req = 12;
        run_frames(4, 13'b0000_0000_10101);
        tick(1'b0, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule